// File: doc/BRIEF.md
# Bandwidth Slot Schedule Generator

This engine produces the arbitration schedule for one memory region. The schedule is a table of 64 slots, and each slot names the client that owns that turn. The engine keeps a requested slot count and an active flag for each of 14 clients. On a rebuild it does three things in order:

- It marks every slot as unassigned.
- It spreads each client that holds a reservation at even spacing across the table.
- It hands each slot that is still empty to the active clients in turn.

The finished schedule is written out on a table write port, one slot per cycle. A done pulse follows the last write.

Software asks for bandwidth on a request port by giving a client index and a bandwidth figure. The engine turns the figure into a slot count and applies an over-subscription check. If the request is accepted, the engine records it and starts a rebuild at once. Each region is its own instance. The region's peak bandwidth and the set of clients active after reset are parameters.

Top module: `slotsched_gen`

## Requirements
- R1: After reset the engine is idle, with no table write, no done pulse and no request result. The clients set in the reset-active mask (by default clients 10 and 11) are active, and every requested count is zero.
- R2: A start pulse while idle begins a rebuild. The table write strobe then stays high for 64 consecutive cycles, with indices 0, 1, ..., 63 in order. The done pulse is high for one cycle, in the cycle after the write of index 63.
- R3: The reserved pass visits clients in increasing index and skips any client whose count is zero. For client c with count n it starts at position 0 and uses a step of floor(64/n). At a free position it places c and then moves forward by the step. It keeps going until the position reaches 64 or more.
- R4: When the position under examination already belongs to a client, the reserved pass moves forward by one position and tries again.
- R5: The fill pass hands each still-unassigned slot, in slot order, to the next active client. The search starts from client 0 on every rebuild and wraps modulo 14. Inactive clients are passed over.
- R6: If no client is active, the fill pass assigns nothing, and every unreserved slot is written as the unassigned marker 15.
- R7: A request's slot count is computed as follows:
  - if the bandwidth is 0, the count is 0;
  - otherwise, let q = floor(peak/bandwidth);
  - if q is 0, the count is 64;
  - otherwise, the count is floor(64/q).
- R8: Taken while idle, a request is rejected when the client index is 14 or higher, or when (sum of stored counts + number of active clients + new count + 1) exceeds 64. An accepted request stores the count, sets the client active and starts a rebuild. A rejected request changes nothing.
- R9: While a rebuild is in progress (busy high, up to and including the done cycle), start pulses are ignored. Any request that arrives in that time is answered as rejected and changes nothing.
- R10: The request result strobe is high for one cycle, in the cycle after the request is presented, and the accept flag is valid during that cycle. Table values are client indices 0 to 13, or 15 for unassigned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Rebuild request pulse |
| rq_valid_i | input | 1 | Bandwidth request strobe |
| rq_client_i | input | 4 | Client index of the request |
| rq_bw_i | input | 32 | Requested bandwidth |
| tbl_we_o | output | 1 | Table write strobe |
| tbl_idx_o | output | 6 | Slot index written |
| tbl_val_o | output | 4 | Client written to the slot, 15 for unassigned |
| done_o | output | 1 | One-cycle pulse after the final table write |
| busy_o | output | 1 | Rebuild in progress |
| rq_done_o | output | 1 | Request result strobe |
| rq_accept_o | output | 1 | Request accepted, valid with rq_done_o |

## Verification
The bench includes a client with a non-power-of-two count (21 slots, step 3). That client lands on positions already taken by a step-4 client. A design that overwrote those positions instead of moving forward by one would drop the other client's slots. A design that restarted the step from the collision point, rather than from the actual placement, would shift every later slot. Requests are chosen to fall on both sides of the over-subscription limit, including one zero-bandwidth request and one above peak. A bad conversion or a wrong sum would flip an accept bit or change the count the table is built from. A separate instance with no active clients shows that a rotation search without a guard either hangs or writes client numbers where the marker belongs. A request and a start injected during a rebuild show whether the engine takes a second rebuild or accepts a request it should refuse.

// File: rtl/slotsched_pkg.sv
package slotsched_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RES,
    ST_FILL,
    ST_DONE
  } sched_state_t;

  localparam logic [31:0] EXT_PEAK_BW = 32'd100_000_000;
  localparam logic [31:0] INT_PEAK_BW = 32'd400_000_000;

endpackage

// File: rtl/slotsched_admit.sv
module slotsched_admit #(
  parameter int          N_CLIENTS = 14,
  parameter int          N_SLOTS   = 64,
  parameter logic [31:0] PEAK_BW   = 32'd100_000_000,
  parameter int          CW        = 4,
  parameter int          RW        = 7
) (
  input  logic [N_CLIENTS-1:0][RW-1:0] req_i,
  input  logic [N_CLIENTS-1:0]         act_i,
  input  logic [CW-1:0]                client_i,
  input  logic [31:0]                  bw_i,
  output logic [RW-1:0]                slots_o,
  output logic                         ok_o
);

  localparam int AW = RW + $clog2(N_CLIENTS + 1) + 1;

  logic [31:0]   ratio;
  logic [AW-1:0] total;

  // R7: bandwidth figure to slot count
  always_comb begin
    ratio = (bw_i == 32'd0) ? 32'd0 : PEAK_BW / bw_i;
    if (bw_i == 32'd0) begin
      slots_o = '0;
    end else if (ratio == 32'd0) begin
      slots_o = RW'(N_SLOTS);
    end else begin
      slots_o = RW'(32'(N_SLOTS) / ratio);
    end
  end

  // R8: over-subscription rule
  always_comb begin
    total = AW'(slots_o) + AW'(1);
    for (int i = 0; i < N_CLIENTS; i++) begin
      total = total + AW'(req_i[i]) + AW'(act_i[i]);
    end
    ok_o = (client_i < CW'(N_CLIENTS)) && (total <= AW'(N_SLOTS));
  end

endmodule

// File: rtl/slotsched_rotor.sv
module slotsched_rotor #(
  parameter int N_CLIENTS = 14,
  parameter int CW        = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_CLIENTS-1:0] act_i,
  input  logic [CW-1:0]        ptr_i,
  output logic                 found_o,
  output logic [CW-1:0]        pick_o
);

  // first active client at or after ptr_i, wrapping
  always_comb begin
    found_o = 1'b0;
    pick_o  = '0;
    for (int k = N_CLIENTS - 1; k >= 0; k--) begin
      int idx;
      idx = int'(ptr_i) + k;
      if (idx >= N_CLIENTS) idx = idx - N_CLIENTS;
      if (act_i[idx]) begin
        found_o = 1'b1;
        pick_o  = CW'(idx);
      end
    end
  end

  a_r5_pick_is_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> act_i[pick_o]);

  a_r6_none_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == '0) |-> !found_o);

endmodule

// File: rtl/slotsched_gen.sv
module slotsched_gen
  import slotsched_pkg::*;
#(
  parameter int                   N_CLIENTS   = 14,
  parameter int                   N_SLOTS     = 64,
  parameter logic [31:0]          PEAK_BW     = EXT_PEAK_BW,
  parameter logic [N_CLIENTS-1:0] BOOT_ACTIVE = N_CLIENTS'(12'hC00),
  parameter int                   CW          = $clog2(N_CLIENTS + 2),
  parameter int                   SW          = $clog2(N_SLOTS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          rq_valid_i,
  input  logic [CW-1:0] rq_client_i,
  input  logic [31:0]   rq_bw_i,
  output logic          tbl_we_o,
  output logic [SW-1:0] tbl_idx_o,
  output logic [CW-1:0] tbl_val_o,
  output logic          done_o,
  output logic          busy_o,
  output logic          rq_done_o,
  output logic          rq_accept_o
);

  localparam int            PW    = SW + 2;
  localparam int            RW    = $clog2(N_SLOTS + 1);
  localparam logic [CW-1:0] MARK  = CW'(N_CLIENTS + 1);
  localparam logic [CW-1:0] LASTC = CW'(N_CLIENTS - 1);
  localparam logic [SW-1:0] LASTS = SW'(N_SLOTS - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  sched_state_t                st_q, st_d;
  logic [CW-1:0]               cli_q, cli_d, rp_q, rp_d;
  logic [PW-1:0]               pos_q, pos_d, step;
  logic [SW-1:0]               slot_q, slot_d;
  logic [N_CLIENTS-1:0][RW-1:0] req_q, req_d;
  logic [N_CLIENTS-1:0]        act_q, act_d;
  logic                        rqd_q, rqd_d, rqa_q, rqa_d;
  logic [CW-1:0]               sched_q [N_SLOTS];
  logic                        sched_clr, sched_we;
  logic                        adm_ok, rot_found;
  logic [RW-1:0]               adm_slots;
  logic [CW-1:0]               rot_pick;

  slotsched_admit #(
    .N_CLIENTS(N_CLIENTS), .N_SLOTS(N_SLOTS), .PEAK_BW(PEAK_BW), .CW(CW), .RW(RW)
  ) u_admit (
    .req_i   (req_q),
    .act_i   (act_q),
    .client_i(rq_client_i),
    .bw_i    (rq_bw_i),
    .slots_o (adm_slots),
    .ok_o    (adm_ok)
  );

  slotsched_rotor #(.N_CLIENTS(N_CLIENTS), .CW(CW)) u_rotor (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .act_i  (act_q),
    .ptr_i  (rp_q),
    .found_o(rot_found),
    .pick_o (rot_pick)
  );

  // next-state logic
  always_comb begin
    st_d      = st_q;
    cli_d     = cli_q;
    pos_d     = pos_q;
    slot_d    = slot_q;
    rp_d      = rp_q;
    req_d     = req_q;
    act_d     = act_q;
    rqd_d     = rq_valid_i;
    rqa_d     = 1'b0;
    sched_clr = 1'b0;
    sched_we  = 1'b0;
    tbl_we_o  = 1'b0;
    tbl_idx_o = slot_q;
    tbl_val_o = sched_q[slot_q];
    done_o    = 1'b0;
    step      = (req_q[cli_q] == '0) ? '0 : PW'(N_SLOTS / int'(req_q[cli_q]));

    unique case (st_q)
      ST_IDLE: begin
        if (rq_valid_i && adm_ok) begin
          rqa_d              = 1'b1;
          req_d[rq_client_i] = adm_slots;
          act_d[rq_client_i] = 1'b1;
        end
        if (start_i || (rq_valid_i && adm_ok)) begin
          st_d      = ST_RES;
          cli_d     = '0;
          pos_d     = '0;
          sched_clr = 1'b1;
        end
      end
      ST_RES: begin
        if (req_q[cli_q] == '0 || pos_q >= PW'(N_SLOTS)) begin
          pos_d = '0;
          if (cli_q == LASTC) begin
            st_d   = ST_FILL;
            slot_d = '0;
            rp_d   = '0;
          end else begin
            cli_d = cli_q + CW'(1);
          end
        end else if (sched_q[pos_q[SW-1:0]] != MARK) begin
          pos_d = pos_q + PW'(1);
        end else begin
          sched_we = 1'b1;
          pos_d    = pos_q + step;
        end
      end
      ST_FILL: begin
        tbl_we_o = 1'b1;
        if (sched_q[slot_q] == MARK && rot_found) begin
          tbl_val_o = rot_pick;
          rp_d      = (rot_pick == LASTC) ? '0 : rot_pick + CW'(1);
        end
        if (slot_q == LASTS) st_d = ST_DONE;
        else                 slot_d = slot_q + SW'(1);
      end
      ST_DONE: begin
        done_o = 1'b1;
        st_d   = ST_IDLE;
      end
    endcase
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign rq_done_o   = rqd_q;
  assign rq_accept_o = rqa_q;

  // registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cli_q  <= '0;
      pos_q  <= '0;
      slot_q <= '0;
      rp_q   <= '0;
      req_q  <= '0;
      act_q  <= BOOT_ACTIVE;
      rqd_q  <= 1'b0;
      rqa_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cli_q  <= cli_d;
      pos_q  <= pos_d;
      slot_q <= slot_d;
      rp_q   <= rp_d;
      req_q  <= req_d;
      act_q  <= act_d;
      rqd_q  <= rqd_d;
      rqa_q  <= rqa_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SLOTS; i++) sched_q[i] <= MARK;
    end else if (sched_clr) begin
      for (int i = 0; i < N_SLOTS; i++) sched_q[i] <= MARK;
    end else if (sched_we) begin
      sched_q[pos_q[SW-1:0]] <= cli_q;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_n)
    !busy_o |-> (!tbl_we_o && !done_o));

  a_r2_index_steps: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tbl_we_o && tbl_idx_o != LASTS) |=> (tbl_we_o && tbl_idx_o == $past(tbl_idx_o) + SW'(1)));

  a_r2_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tbl_we_o && tbl_idx_o == LASTS) |=> (done_o && !tbl_we_o));

  a_r8_accept_launches: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rq_done_o && rq_accept_o) |-> busy_o);

  a_r9_busy_rejects: assert property (@(posedge clk_i) disable iff (!rst_n)
    (busy_o && rq_valid_i) |=> (rq_done_o && !rq_accept_o));

  a_r9_done_ends: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |=> !busy_o);

  a_r10_value_legal: assert property (@(posedge clk_i) disable iff (!rst_n)
    tbl_we_o |-> (tbl_val_o < CW'(N_CLIENTS) || tbl_val_o == MARK));

endmodule

// File: tb/slotsched_gen_test.sv
module slotsched_gen_test;

  localparam int NC = 14;
  localparam int NS = 64;
  localparam int UN = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, start_e = 1'b0;
  logic        rq_valid = 1'b0;
  logic [3:0]  rq_client = '0;
  logic [31:0] rq_bw = '0;
  logic        we, done, busy, rq_done, rq_acc;
  logic [5:0]  idx;
  logic [3:0]  val;
  logic        we_e, done_e, busy_e, rqd_e, rqa_e;
  logic [5:0]  idx_e;
  logic [3:0]  val_e;

  int n_tests = 0, n_fail = 0;
  int mreq [NC];
  int mact [NC];
  int exp_tbl [NS];

  always #4 clk = ~clk;

  slotsched_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rq_valid_i(rq_valid),
    .rq_client_i(rq_client), .rq_bw_i(rq_bw), .tbl_we_o(we), .tbl_idx_o(idx),
    .tbl_val_o(val), .done_o(done), .busy_o(busy), .rq_done_o(rq_done),
    .rq_accept_o(rq_acc));

  slotsched_gen #(.BOOT_ACTIVE(14'h0)) uut_empty (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_e), .rq_valid_i(1'b0),
    .rq_client_i(4'd0), .rq_bw_i(32'd0), .tbl_we_o(we_e), .tbl_idx_o(idx_e),
    .tbl_val_o(val_e), .done_o(done_e), .busy_o(busy_e), .rq_done_o(rqd_e),
    .rq_accept_o(rqa_e));

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic int model_slots(input longint bw);
    longint q;
    if (bw == 0) return 0;
    q = 100000000 / bw;
    if (q == 0) return 64;
    return int'(64 / q);
  endfunction

  function automatic bit model_admit(input int c, input int sl);
    int tot;
    if (c >= NC) return 1'b0;
    tot = sl + 1;
    for (int i = 0; i < NC; i++) tot += mreq[i] + mact[i];
    return tot <= NS;
  endfunction

  // behavioural schedule: reserved spread, then rotating fill
  task automatic build_exp();
    int r;
    bit any;
    for (int s = 0; s < NS; s++) exp_tbl[s] = UN;
    for (int c = 0; c < NC; c++) begin
      int p, iv;
      if (mreq[c] == 0) continue;
      iv = NS / mreq[c];
      p = 0;
      while (p < NS) begin
        if (exp_tbl[p] != UN) p++;
        else begin exp_tbl[p] = c; p += iv; end
      end
    end
    any = 1'b0;
    for (int c = 0; c < NC; c++) if (mact[c] != 0) any = 1'b1;
    r = 0;
    for (int s = 0; s < NS; s++) begin
      if (exp_tbl[s] == UN && any) begin
        while (mact[r] == 0) r = (r + 1) % NC;
        exp_tbl[s] = r;
        r = (r + 1) % NC;
      end
    end
  endtask

  // compares the write stream on every clock; inj >= 0 injects start+request
  task automatic collect(input string rq, input int inj);
    int n = 0;
    bit fin = 1'b0;
    bit prev_we = 1'b0;
    for (int cyc = 0; cyc < 4000 && !fin; cyc++) begin
      if (inj >= 0 && cyc == inj + 1)
        check(rq_done && !rq_acc, "R9", "request during rebuild result", int'(rq_acc), 0);
      if (we) begin
        check(int'(idx) == n, "R2", "write index", int'(idx), n);
        if (n < NS) check(int'(val) == exp_tbl[n], rq, $sformatf("slot %0d value", n),
                          int'(val), exp_tbl[n]);
        n++;
      end
      if (done) begin
        check(n == NS && prev_we, "R2", "done after 64th write", n, NS);
        fin = 1'b1;
      end
      prev_we = we;
      if (inj >= 0 && cyc == inj) begin
        start = 1'b1; rq_valid = 1'b1; rq_client = 4'd1; rq_bw = 32'd1_000_000;
      end else begin
        start = 1'b0; rq_valid = 1'b0;
      end
      if (!fin) @(negedge clk);
    end
    if (!fin) check(1'b0, rq, "rebuild never finished", n, NS);
  endtask

  task automatic start_rebuild(input string rq);
    build_exp();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    collect(rq, -1);
  endtask

  task automatic request(input int c, input longint bw, input string rq);
    int sl;
    bit ok;
    sl = model_slots(bw);
    ok = model_admit(c, sl);
    @(negedge clk) begin
      rq_valid = 1'b1; rq_client = 4'(c); rq_bw = 32'(bw);
    end
    @(negedge clk) rq_valid = 1'b0;
    check(rq_done == 1'b1, "R10", "result strobe", int'(rq_done), 1);
    check(rq_acc == ok, rq, "accept flag", int'(rq_acc), int'(ok));
    if (ok) begin
      mreq[c] = sl;
      mact[c] = 1;
      build_exp();
      collect(rq, -1);
    end else begin
      @(negedge clk);
      check(!busy && !we, "R8", "no rebuild after reject", int'(busy), 0);
      check(!rq_done, "R10", "result strobe one cycle", int'(rq_done), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NC; i++) begin mreq[i] = 0; mact[i] = 0; end
    mact[10] = 1;
    mact[11] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: idle after reset
    check(!busy && !we && !done && !rq_done, "R1", "idle outputs", int'(busy), 0);

    // R1 R5: reset-active clients rotate through the table
    start_rebuild("R5");

    // R7 R8 R3: 25e6 -> 16 slots, step 4
    request(0, 25_000_000, "R3");
    // R4 R7: 30e6 -> 21 slots, step 3, collides with client 0
    request(3, 30_000_000, "R4");
    // R8: over the limit (37 + 4 + 32 + 1 > 64)
    request(5, 50_000_000, "R8");
    start_rebuild("R8");
    // R3 R7: zero bandwidth -> count 0, joins rotation only
    request(7, 0, "R3");
    // R7: above peak -> 64 slots, rejected
    request(2, 200_000_000, "R7");
    // R8: client index out of range
    request(14, 1_000_000, "R8");

    // R9: start and request during a rebuild
    build_exp();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    collect("R9", 20);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(!busy && !we, "R9", "no second rebuild", int'(busy), 0);
    end
    start_rebuild("R9");

    // R6: no active clients, everything stays unassigned
    @(negedge clk) start_e = 1'b1;
    @(negedge clk) start_e = 1'b0;
    begin
      int n = 0;
      bit fin = 1'b0;
      for (int cyc = 0; cyc < 4000 && !fin; cyc++) begin
        if (we_e) begin
          check(int'(val_e) == UN, "R6", "unassigned marker", int'(val_e), UN);
          n++;
        end
        if (done_e) fin = 1'b1;
        else @(negedge clk);
      end
      check(fin && n == NS, "R6", "empty rebuild completes", n, NS);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule